// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block drives one programmable operation on an 8-bit NAND flash bus, such as a block erase. Software first loads a set of registers: a chip-enable bit, an access-mode field, the enabled stages, two command codes, an address word and a strobe width. It then writes the start bit. The sequencer can run up to four stages, always in the same order. The first is a command byte. Next come one to four address bytes. Then comes a second command byte. The last stage waits for the flash to report ready and reads its status byte. When the sequence ends, a sticky end flag is set and the captured status byte is held for software.

Every byte written to the flash is driven with CLE or ALE set to match the byte's type. The byte is latched by a write-strobe low pulse whose width is programmable. The status stage first waits for the ready/busy line to go low and then high again, and this wait is bounded by a timeout. It then issues the status command and samples the data bus during a read-strobe low pulse.

The state machine has these states:
- `S_IDLE`
- `S_SETUP`: byte driven, strobe high.
- `S_WLOW`: write strobe low.
- `S_HOLD`: byte held, strobe high.
- `S_WAIT_LOW`: waiting for busy.
- `S_WAIT_HIGH`: waiting for ready.
- `S_RLOW`: read strobe low.
- `S_FINISH`

It makes these transitions:
- IDLE→(first enabled stage) on an accepted start.
- SETUP→WLOW.
- WLOW→HOLD after the strobe width.
- HOLD→SETUP for the next address byte.
- HOLD→RLOW after the status command.
- HOLD→(next enabled stage) otherwise.
- WAIT_LOW→WAIT_HIGH when busy is seen.
- WAIT_LOW or WAIT_HIGH→SETUP on ready or on timeout.
- RLOW→FINISH after the strobe width.
- FINISH→IDLE.

An enabled stage runs and a disabled one is skipped. When no later stage is enabled, the machine goes to FINISH.

Top module: `nand_cmd_seq`

## Requirements
- R1: The register map is as follows. Each write takes effect at the clock edge where `reg_wr` is high. Each read is combinational on `reg_raddr`.
  - Offset 0: bit0 chip enable, bits 2:1 access mode.
  - Offset 1: bit0 command-1 stage, bit1 address stage, bit2 command-2 stage, bit3 status stage, bits 5:4 address count, bit6 address source.
  - Offset 2: command codes.
  - Offset 3: address bits 15:0.
  - Offset 4: address bits 31:16.
  - Offset 5: bit0 start (write) / busy (read), bit1 end flag.
  - Offset 6: status in bits 7:0.
  - Offset 7: strobe width in bits 3:0.
- R2: Enabled stages run in the order command 1, address, command 2, status. A disabled stage issues no bytes.
- R3: The command-1 byte is code bits 7:0, and the command-2 byte is code bits 15:8 (for example 0x60 then 0xD0 for a block erase).
- R4: The address stage issues count+1 bytes, where counts 0 to 3 give one to four bytes. The bytes go least significant first. When the address source is 1 they come from the address register; when it is 0 each byte is 0x00.
- R5: Command bytes are driven with CLE=1 and ALE=0. Address bytes are driven with ALE=1 and CLE=0. The data bus stays stable while the write strobe is low.
- R6: Each write-strobe and read-strobe low pulse lasts the programmed width in clocks, and a width of 0 acts as 1.
- R7: The status stage waits for R/B# to go low and then high, or for TIMEOUT_CYCLES clocks to pass. It then issues command 0x70 and stores the bus byte sampled at the end of the read-strobe pulse as the status.
- R8: The end flag is set when the sequence finishes. Writing offset 5 with bit1=0 clears the flag, and writing bit1=1 leaves it unchanged.
- R9: A start is ignored while a sequence runs. It is also ignored when the access mode is not 00.
- R10: `nand_ce_n` is the inverse of the chip-enable bit.
- R11: After reset, all strobes are high, CLE and ALE are low, the bus is not driven, CE# is high, the end flag is 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write offset |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | 3 | Read offset |
| reg_rdata | output | 16 | Read data |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rb_n | input | 1 | Ready (1) / busy (0) from flash |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data in |

## Verification
The bench draws random stage masks, address counts, address sources, strobe widths and busy lengths. Each captured byte stream is compared with one built by a bench function. A skipped stage that leaked a byte, or an address sent most significant first, would show up as a count or data mismatch. Operations where R/B# never goes low drive the timeout path; a design lacking it would hang and trip the per-operation limit. Directed cases cover the following, each of which would otherwise show extra bytes, a lost or spuriously set end flag, or an off-by-one strobe width:
- a start written mid-sequence;
- a start written in a non-command access mode;
- writing 1 to the end flag;
- a zero strobe width.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int REG_AW = 3;
    localparam int REG_DW = 16;

    localparam logic [REG_AW-1:0] REG_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] REG_STAGE = 3'd1;
    localparam logic [REG_AW-1:0] REG_CODES = 3'd2;
    localparam logic [REG_AW-1:0] REG_ADRLO = 3'd3;
    localparam logic [REG_AW-1:0] REG_ADRHI = 3'd4;
    localparam logic [REG_AW-1:0] REG_XFER  = 3'd5;
    localparam logic [REG_AW-1:0] REG_STAT  = 3'd6;
    localparam logic [REG_AW-1:0] REG_TIME  = 3'd7;

    localparam logic [7:0] STATUS_CMD = 8'h70;

    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_WLOW, S_HOLD,
        S_WAIT_LOW, S_WAIT_HIGH, S_RLOW, S_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        STG_CMD1 = 2'd0, STG_ADDR = 2'd1, STG_CMD2 = 2'd2, STG_STAT = 2'd3
    } stage_t;

    typedef struct packed {
        logic [3:0]  stage_en;
        logic [1:0]  addr_cnt;
        logic        addr_src;
        logic [15:0] codes;
        logic [31:0] addr;
        logic [3:0]  pulse_w;
    } seq_cfg_t;

endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
    import nand_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [REG_DW-1:0] rd_data,
    input  logic              busy,
    input  logic              done,
    input  logic              stat_vld,
    input  logic [7:0]        stat_byte,
    output seq_cfg_t          cfg,
    output logic              chip_en,
    output logic              start
);

    logic [1:0]  acc_mode;
    logic        end_flag;
    logic [7:0]  status_q;

    assign start = wr_en && (wr_addr == REG_XFER) && wr_data[0]
                   && !busy && (acc_mode == 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chip_en  <= 1'b0;
            acc_mode <= 2'b00;
            cfg      <= '0;
            end_flag <= 1'b0;
            status_q <= 8'h00;
        end else begin
            if (wr_en) begin
                unique case (wr_addr)
                    REG_CTRL:  begin chip_en <= wr_data[0]; acc_mode <= wr_data[2:1]; end
                    REG_STAGE: begin
                        cfg.stage_en <= wr_data[3:0];
                        cfg.addr_cnt <= wr_data[5:4];
                        cfg.addr_src <= wr_data[6];
                    end
                    REG_CODES: cfg.codes       <= wr_data;
                    REG_ADRLO: cfg.addr[15:0]  <= wr_data;
                    REG_ADRHI: cfg.addr[31:16] <= wr_data;
                    REG_XFER:  if (!wr_data[1]) end_flag <= 1'b0;
                    REG_TIME:  cfg.pulse_w     <= wr_data[3:0];
                    default: ;
                endcase
            end
            if (done)     end_flag <= 1'b1;
            if (stat_vld) status_q <= stat_byte;
        end
    end

    always_comb begin
        unique case (rd_addr)
            REG_CTRL:  rd_data = {13'b0, acc_mode, chip_en};
            REG_STAGE: rd_data = {9'b0, cfg.addr_src, cfg.addr_cnt, cfg.stage_en};
            REG_CODES: rd_data = cfg.codes;
            REG_ADRLO: rd_data = cfg.addr[15:0];
            REG_ADRHI: rd_data = cfg.addr[31:16];
            REG_XFER:  rd_data = {14'b0, end_flag, busy};
            REG_STAT:  rd_data = {8'b0, status_q};
            REG_TIME:  rd_data = {12'b0, cfg.pulse_w};
            default:   rd_data = '0;
        endcase
    end

    // R8: completion sets the sticky flag
    p_end_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> end_flag);

    // R8: writing one to the flag does not set it
    p_end_w1_noeffect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_XFER && wr_data[1] && !end_flag && !done) |=> !end_flag);

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  seq_cfg_t   cfg,
    input  logic       rb_n,
    input  logic [7:0] dq_i,
    output logic       busy,
    output logic       done,
    output logic       stat_vld,
    output logic [7:0] stat_byte,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] dq_o,
    output logic       dq_oe
);

    localparam int TOW = $clog2(TIMEOUT_CYCLES + 1);
    localparam int CW  = (TOW > 4) ? TOW : 4;
    localparam logic [CW-1:0] TO_LAST = CW'(TIMEOUT_CYCLES - 1);

    seq_state_t    state, state_d;
    stage_t        stage, stage_d;
    logic [1:0]    abyte, abyte_d;
    logic [CW-1:0] cnt, cnt_d;
    logic [1:0]    rb_sync;
    logic          rb_ok;
    logic [CW-1:0] pw_last;
    logic [2:0]    first_stg, next_stg;

    function automatic logic [2:0] pick(input logic [2:0] from, input logic [3:0] en);
        logic [2:0] r;
        r = 3'd4;
        for (int i = 3; i >= 0; i--) begin
            if (3'(i) >= from && en[i]) r = 3'(i);
        end
        return r;
    endfunction

    assign rb_ok     = rb_sync[1];
    assign pw_last   = (cfg.pulse_w == 4'd0) ? '0 : CW'(cfg.pulse_w - 4'd1);
    assign first_stg = pick(3'd0, cfg.stage_en);
    assign next_stg  = pick({1'b0, stage} + 3'd1, cfg.stage_en);

    always_comb begin
        logic [2:0] tgt;
        state_d  = state;
        stage_d  = stage;
        abyte_d  = abyte;
        cnt_d    = cnt;
        tgt      = 3'd7;
        stat_vld = 1'b0;
        unique case (state)
            S_IDLE:  if (start) tgt = first_stg;
            S_SETUP: begin state_d = S_WLOW; cnt_d = '0; end
            S_WLOW: begin
                cnt_d = cnt + 1'b1;
                if (cnt == pw_last) state_d = S_HOLD;
            end
            S_HOLD: begin
                if (stage == STG_ADDR && abyte != cfg.addr_cnt) begin
                    abyte_d = abyte + 2'd1;
                    state_d = S_SETUP;
                end else if (stage == STG_STAT) begin
                    state_d = S_RLOW;
                    cnt_d   = '0;
                end else begin
                    tgt = next_stg;
                end
            end
            S_WAIT_LOW: begin
                cnt_d = cnt + 1'b1;
                if (!rb_ok)              state_d = S_WAIT_HIGH;
                else if (cnt == TO_LAST) state_d = S_SETUP;
            end
            S_WAIT_HIGH: begin
                cnt_d = cnt + 1'b1;
                if (rb_ok || cnt == TO_LAST) state_d = S_SETUP;
            end
            S_RLOW: begin
                cnt_d = cnt + 1'b1;
                if (cnt == pw_last) begin
                    stat_vld = 1'b1;
                    state_d  = S_FINISH;
                end
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
        if (tgt == 3'd4) begin
            state_d = S_FINISH;
        end else if (tgt < 3'd4) begin
            stage_d = stage_t'(tgt[1:0]);
            abyte_d = 2'd0;
            cnt_d   = '0;
            state_d = (tgt == 3'd3) ? S_WAIT_LOW : S_SETUP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            stage   <= STG_CMD1;
            abyte   <= 2'd0;
            cnt     <= '0;
            rb_sync <= 2'b11;
        end else begin
            state   <= state_d;
            stage   <= stage_d;
            abyte   <= abyte_d;
            cnt     <= cnt_d;
            rb_sync <= {rb_sync[0], rb_n};
        end
    end

    always_comb begin
        logic in_byte;
        in_byte   = (state == S_SETUP) || (state == S_WLOW) || (state == S_HOLD);
        cle       = in_byte && (stage != STG_ADDR);
        ale       = in_byte && (stage == STG_ADDR);
        we_n      = (state != S_WLOW);
        re_n      = (state != S_RLOW);
        dq_oe     = in_byte;
        busy      = (state != S_IDLE);
        done      = (state == S_FINISH);
        stat_byte = dq_i;
        unique case (stage)
            STG_CMD1: dq_o = cfg.codes[7:0];
            STG_CMD2: dq_o = cfg.codes[15:8];
            STG_ADDR: dq_o = cfg.addr_src ? cfg.addr[{abyte, 3'b000} +: 8] : 8'h00;
            default:  dq_o = STATUS_CMD;
        endcase
    end

    // R5: latch enables never both high
    p_cle_ale_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R5: bus stable through a write strobe
    p_dq_stable_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> $stable(dq_o));

    // R6: strobes never overlap
    p_we_re_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    // R7: a read strobe only follows the status command
    p_read_after_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(re_n) |-> ($past(state) == S_HOLD && $past(stage) == STG_STAT));

    // R11: idle keeps the bus quiet
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (we_n && re_n && !dq_oe && !cle && !ale));

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_waddr,
    input  logic [15:0] reg_wdata,
    input  logic [2:0]  reg_raddr,
    output logic [15:0] reg_rdata,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    input  logic        nand_rb_n,
    output logic [7:0]  nand_dq_o,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_i
);

    seq_cfg_t   cfg;
    logic       chip_en, start, busy, done, stat_vld;
    logic [7:0] stat_byte;

    nand_seq_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .wr_addr(reg_waddr), .wr_data(reg_wdata),
        .rd_addr(reg_raddr), .rd_data(reg_rdata),
        .busy(busy), .done(done), .stat_vld(stat_vld), .stat_byte(stat_byte),
        .cfg(cfg), .chip_en(chip_en), .start(start)
    );

    nand_seq_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg),
        .rb_n(nand_rb_n), .dq_i(nand_dq_i),
        .busy(busy), .done(done), .stat_vld(stat_vld), .stat_byte(stat_byte),
        .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
        .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
    );

    assign nand_ce_n = !chip_en;

endmodule

// File: tb/test_nand_cmd_seq.sv
`timescale 1ns/1ps
module test_nand_cmd_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_waddr = '0, reg_raddr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic        nand_rb_n = 1'b1;
    logic [7:0]  nand_dq_o;
    logic [7:0]  nand_dq_i = '0;

    always #4 clk = ~clk;

    nand_cmd_seq i_nand_cmd_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_rb_n(nand_rb_n),
        .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i)
    );

    int n_chk = 0, n_fail = 0;
    int pw_chk = 0, pw_fail = 0;
    int exp_w = 1;
    int busy_len = 0;
    logic [7:0] cur_cmd2 = '0;
    bit  cur_cmd2_en = 0;

    // byte capture on write-strobe rising edge
    int rec_total = 0, trig_cnt = 0;
    logic [7:0] rec_dat [64];
    logic [1:0] rec_ca  [64];
    always @(posedge nand_we_n) begin
        if (rst_n) begin
            rec_dat[rec_total % 64] = nand_dq_o;
            rec_ca[rec_total % 64]  = {nand_cle, nand_ale};
            rec_total++;
            if (cur_cmd2_en && nand_cle && nand_dq_o == cur_cmd2) trig_cnt++;
        end
    end

    // flash busy model
    int seen_trig = 0, busy_cnt = 0;
    always @(negedge clk) begin
        if (trig_cnt != seen_trig) begin
            seen_trig = trig_cnt;
            busy_cnt  = busy_len;
        end
        if (busy_cnt > 0) begin
            nand_rb_n <= 1'b0;
            busy_cnt--;
        end else begin
            nand_rb_n <= 1'b1;
        end
    end

    // R6: strobe width monitor
    int we_lo = 0, re_lo = 0;
    always @(negedge clk) begin
        if (!nand_we_n) we_lo++;
        else if (we_lo > 0) begin
            pw_chk++;
            if (we_lo != exp_w) begin
                pw_fail++;
                $display("FAIL R6 write strobe width act=%0d exp=%0d", we_lo, exp_w);
            end
            we_lo = 0;
        end
        if (!nand_re_n) re_lo++;
        else if (re_lo > 0) begin
            pw_chk++;
            if (re_lo != exp_w) begin
                pw_fail++;
                $display("FAIL R6 read strobe width act=%0d exp=%0d", re_lo, exp_w);
            end
            re_lo = 0;
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog act=%0d exp<=150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk + pw_chk + 1, n_fail + pw_fail + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_raddr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic run_op(input logic [3:0] en, input logic [1:0] ac, input bit src,
                          input logic [15:0] codes, input logic [31:0] adr,
                          input logic [3:0] pw, input logic [7:0] st, input int bl,
                          input bit dbl_start);
        logic [7:0]  ed [8];
        logic [1:0]  ek [8];
        int n, base, idx;
        logic [15:0] v;
        bit ended;
        cur_cmd2 = codes[15:8]; cur_cmd2_en = en[2]; busy_len = bl;
        nand_dq_i = st; exp_w = (pw == 0) ? 1 : int'(pw);
        wr(3'd1, {9'b0, src, ac, en});
        wr(3'd2, codes);
        wr(3'd3, adr[15:0]);
        wr(3'd4, adr[31:16]);
        wr(3'd7, {12'b0, pw});
        base = rec_total;
        wr(3'd5, 16'h0001);
        if (dbl_start) wr(3'd5, 16'h0001);
        ended = 0;
        for (int i = 0; i < 4000 && !ended; i++) begin
            rd(3'd5, v);
            if (v[1]) ended = 1; else @(negedge clk);
        end
        chk(ended, "R8 end flag after sequence", {31'b0, ended}, 32'd1);
        chk(v[0] == 1'b0, "R9 idle after end", {31'b0, v[0]}, 32'd0);
        n = 0;
        if (en[0]) begin ek[n] = 2'b10; ed[n] = codes[7:0]; n++; end
        if (en[1]) for (int b = 0; b <= int'(ac); b++) begin
            ek[n] = 2'b01; ed[n] = src ? adr[b*8 +: 8] : 8'h00; n++;
        end
        if (en[2]) begin ek[n] = 2'b10; ed[n] = codes[15:8]; n++; end
        if (en[3]) begin ek[n] = 2'b10; ed[n] = 8'h70; n++; end
        if (dbl_start) repeat (40) @(negedge clk);
        chk(rec_total - base == n, "R2/R9 byte count", rec_total - base, n);
        for (int i = 0; i < n && i < rec_total - base; i++) begin
            idx = (base + i) % 64;
            chk(rec_ca[idx] == ek[i], "R5 CLE/ALE level", rec_ca[idx], ek[i]);
            chk(rec_dat[idx] == ed[i], (ek[i] == 2'b01) ? "R4 address byte" : "R3 command byte",
                rec_dat[idx], ed[i]);
        end
        if (en[3]) begin
            rd(3'd6, v);
            chk(v[7:0] == st, "R7 captured status", v, st);
        end
        wr(3'd5, 16'h0002);
        rd(3'd5, v);
        chk(v[1] == 1'b1, "R8 write one keeps flag", v, 32'h2);
        wr(3'd5, 16'h0000);
        rd(3'd5, v);
        chk(v[1] == 1'b0, "R8 write zero clears flag", v, 32'h0);
    endtask

    initial begin
        logic [15:0] v;
        int base;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe && nand_ce_n,
            "R11 pins after reset",
            {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, nand_ce_n}, 6'b110001);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd5, v);
        chk(v == 16'h0000, "R11 idle and end flag clear", v, 16'h0);

        // R10: chip enable
        wr(3'd0, 16'h0001);
        chk(nand_ce_n == 1'b0, "R10 CE# active", nand_ce_n, 1'b0);
        wr(3'd0, 16'h0000);
        chk(nand_ce_n == 1'b1, "R10 CE# inactive", nand_ce_n, 1'b1);
        wr(3'd0, 16'h0001);

        // R1: register readback
        wr(3'd2, 16'hD060);
        rd(3'd2, v);
        chk(v == 16'hD060, "R1 command code readback", v, 16'hD060);

        // directed block erase, two address bytes, all stages
        run_op(4'b1111, 2'b01, 1'b1, 16'hD060, 32'h0000_A53C, 4'd2, 8'hE0, 6, 1'b0);
        // zero strobe width, four address bytes
        run_op(4'b0010, 2'b11, 1'b1, 16'h0000, 32'h1234_5678, 4'd0, 8'h00, 0, 1'b0);
        // R7 timeout: no busy response
        run_op(4'b1100, 2'b00, 1'b0, 16'h3011, 32'h0, 4'd1, 8'h5A, 0, 1'b0);
        // R9: second start mid sequence ignored
        run_op(4'b1111, 2'b10, 1'b1, 16'h1080, 32'h00CC_BBAA, 4'd3, 8'hC1, 8, 1'b1);

        // R9: non-command access mode ignores start
        wr(3'd0, 16'h0003);
        base = rec_total;
        wr(3'd5, 16'h0001);
        repeat (30) @(negedge clk);
        rd(3'd5, v);
        chk(v == 16'h0000 && rec_total == base, "R9 start ignored in mode 01", v, 16'h0);
        wr(3'd0, 16'h0001);

        // random operations
        for (int k = 0; k < 40; k++) begin
            logic [3:0] en;
            en = 4'($urandom_range(0, 15));
            run_op(en, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                   16'($urandom), 32'($urandom), 4'($urandom_range(0, 4)),
                   8'($urandom), ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(4, 12)),
                   1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + pw_chk, n_fail + pw_fail);
        $finish;
    end

endmodule